// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 management transactions on a two-wire PHY management bus. A host pulses a start strobe with a direction select, a 5-bit PHY address, a register address and, for writes, a 16-bit value. The block then produces the clock and the data bit stream on its own. While a transaction is running, busy stays high. A one-cycle done pulse marks completion.

The management clock is derived from the system clock by a fixed half-period divider. Each bit is placed on the line while the clock is low and is taken by the PHY on the rising edge. Incoming bits are sampled in the last system cycle of the low phase. The data pad is a tristate buffer: the block drives an output value and an output enable, and it reads the pad level back on a separate input. A per-request flag adds a run of ones before the frame, for PHYs that need a sync run.

Reads and writes have different frame shapes. A read sends a short header, releases the line and clocks in turnaround, data and an idle bit. A write sends one full word and then gives two released clocks. A register address outside the 5-bit range is refused at once, with no bus activity.

Top module: `mdio_master`

## Requirements
- R1: After reset, mdc is 0, mdioOe is 0, mdioOut is 1, busy is 0, done is 0 and rdData is 0.
- R2: When preambleEn is high at start, the block drives 32 one bits before the frame. When preambleEn is low, no extra bits are driven.
- R3: A read drives 16 header bits, most significant first: 1,1,0,1,1,0, then phyAddr[4:0], then regAddr[4:0].
- R4: After the read header, mdioOe is 0 for exactly 19 clock periods. rdData receives the 3rd through 18th sampled bits, first sample at bit 15. The first two samples and the last one are discarded.
- R5: A write drives 32 bits, most significant first: 0,1,0,1, phyAddr, regAddr[4:0], 1,0, then wrData[15:0].
- R6: After the 32 write bits, mdioOe is 0 for exactly 2 more clock periods, and then the transaction ends.
- R7: mdc spends exactly HALF_DIV system cycles high per bit. This gives at most 2.5 MHz at 100 MHz with the default setting. A driven bit changes only while mdc is low.
- R8: A start with regAddr[5] set produces no mdc edge and no driven bit, and done is raised the next cycle. On a read, rdData becomes 0xFFFF. On a write, rdData is left unchanged.
- R9: A start while busy is ignored. It produces no extra frame and no extra done.
- R10: done is high for one cycle per accepted request. rdData changes only in the done cycle and otherwise holds, so a write leaves the last read value in place.
- R11: mdioOe is 0 while idle and during every released bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken when not busy |
| isRead | input | 1 | 1 selects read, 0 selects write |
| preambleEn | input | 1 | Adds the 32-bit run of ones before the frame |
| phyAddr | input | 5 | PHY address |
| regAddr | input | 6 | Register address; bit 5 set means out of range |
| wrData | input | 16 | Write value |
| rdData | output | 16 | Read result, held until the next completion |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Pad output value |
| mdioOe | output | 1 | Pad output enable |
| mdioIn | input | 1 | Pad level sampled back |

## Verification
Two things can fall in the same cycle. One is a new start strobe that arrives while a frame is being shifted; the other is the register update that finishes that frame. The bench provokes the clash by pulsing start with a different address and direction in the middle of a preambled write. The scoreboard then requires exactly one done, with the write's bit stream intact and the read value unchanged. A second collision happens in every completing read: the result capture and the done pulse happen in the same cycle. The bench checks that the new rdData is visible when done is seen and stays put afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_TX,
    ST_RX,
    ST_TAIL
  } mdioState_t;

  // strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic load;
    logic reject;
    logic shiftTx;
    logic sampleRx;
    logic capture;
  } dpCtl_t;

  localparam int PRE_BITS  = 32;
  localparam int RD_HDR    = 16;
  localparam int WR_BITS   = 32;
  localparam int RD_BITS   = 19;
  localparam int TAIL_BITS = 2;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   isRead,
  input  logic   preambleEn,
  input  logic   regHigh,
  output logic   busy,
  output logic   done,
  output logic   mdc,
  output logic   oe,
  output logic   txActive,
  output dpCtl_t dpCtl
);
  localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_DIV - 1);
  localparam int CW = 6;

  mdioState_t state;
  logic [TW-1:0] timer;
  logic [CW-1:0] bitCnt;
  logic mdcR, opRead, doneR;
  logic halfEnd, bitEnd, riseNow, accept;

  assign halfEnd = (timer == LAST);
  assign bitEnd  = mdcR && halfEnd;
  assign riseNow = !mdcR && halfEnd;
  assign accept  = (state == ST_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      mdcR   <= 1'b0;
      bitCnt <= '0;
      opRead <= 1'b0;
      doneR  <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (state == ST_IDLE) begin
        timer <= '0;
        mdcR  <= 1'b0;
        if (start) begin
          opRead <= isRead;
          if (regHigh) begin
            doneR <= 1'b1;
          end else if (preambleEn) begin
            state  <= ST_PRE;
            bitCnt <= CW'(PRE_BITS - 1);
          end else begin
            state  <= ST_TX;
            bitCnt <= isRead ? CW'(RD_HDR - 1) : CW'(WR_BITS - 1);
          end
        end
      end else begin
        timer <= halfEnd ? '0 : timer + 1'b1;
        if (halfEnd) mdcR <= ~mdcR;
        if (bitEnd) begin
          if (bitCnt != '0) begin
            bitCnt <= bitCnt - 1'b1;
          end else begin
            unique case (state)
              ST_PRE: begin
                state  <= ST_TX;
                bitCnt <= opRead ? CW'(RD_HDR - 1) : CW'(WR_BITS - 1);
              end
              ST_TX: begin
                state  <= opRead ? ST_RX : ST_TAIL;
                bitCnt <= opRead ? CW'(RD_BITS - 1) : CW'(TAIL_BITS - 1);
              end
              default: begin
                state <= ST_IDLE;
                doneR <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    dpCtl          = '0;
    dpCtl.load     = accept && !regHigh;
    dpCtl.reject   = accept && regHigh;
    dpCtl.shiftTx  = (state == ST_TX) && bitEnd;
    dpCtl.sampleRx = (state == ST_RX) && riseNow;
    dpCtl.capture  = (state == ST_RX) && bitEnd && (bitCnt == '0);
  end

  assign busy     = (state != ST_IDLE);
  assign done     = doneR;
  assign mdc      = mdcR;
  assign txActive = (state == ST_TX);
  assign oe       = (state == ST_PRE) || (state == ST_TX);

  assert_reject_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && regHigh) |=> (done && !busy && !mdc));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done || $past(start)));

  assert_idle_released_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!oe && !mdc));

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !bitEnd) |=> busy);
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      dpCtl,
  input  logic        isRead,
  input  logic [4:0]  phyAddr,
  input  logic [4:0]  regLow,
  input  logic [15:0] wrData,
  input  logic        mdioIn,
  output logic        txBit,
  output logic [15:0] rdData
);
  logic [WR_BITS-1:0] txShift;
  logic [RD_BITS-1:0] rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '1;
      rxShift <= '0;
      rdData  <= '0;
    end else begin
      if (dpCtl.load) begin
        if (isRead) txShift <= {6'b110110, phyAddr, regLow, 16'h0000};
        else        txShift <= {4'b0101, phyAddr, regLow, 2'b10, wrData};
      end else if (dpCtl.shiftTx) begin
        txShift <= {txShift[WR_BITS-2:0], 1'b1};
      end
      if (dpCtl.sampleRx) rxShift <= {rxShift[RD_BITS-2:0], mdioIn};
      if (dpCtl.capture) rdData <= rxShift[16:1];
      else if (dpCtl.reject && isRead) rdData <= 16'hFFFF;
    end
  end

  assign txBit = txShift[WR_BITS-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_DIV = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isRead,
  input  logic        preambleEn,
  input  logic [4:0]  phyAddr,
  input  logic [5:0]  regAddr,
  input  logic [15:0] wrData,
  output logic [15:0] rdData,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  dpCtl_t dpCtl;
  logic txActive, txBit;

  mdio_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead),
    .preambleEn(preambleEn), .regHigh(regAddr[5]), .busy(busy),
    .done(done), .mdc(mdc), .oe(mdioOe), .txActive(txActive), .dpCtl(dpCtl)
  );

  mdio_dp u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .isRead(isRead),
    .phyAddr(phyAddr), .regLow(regAddr[4:0]), .wrData(wrData),
    .mdioIn(mdioIn), .txBit(txBit), .rdData(rdData)
  );

  assign mdioOut = txActive ? txBit : 1'b1;

  assert_data_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (mdioOe && $past(mdioOe) && !$stable(mdioOut)) |-> !mdc);

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> $stable(rdData));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, isRead = 1'b0, preambleEn = 1'b0;
  logic [4:0] phyAddr = '0;
  logic [5:0] regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic busy, done, mdc, mdioOut, mdioOe, mdioIn;

  always #5 clk = ~clk;

  mdio_master #(.HALF_DIV(HALF)) u_mdio_master (
    .clk(clk), .rstN(rstN), .start(start), .isRead(isRead),
    .preambleEn(preambleEn), .phyAddr(phyAddr), .regAddr(regAddr),
    .wrData(wrData), .rdData(rdData), .busy(busy), .done(done),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [79:0] act, input logic [79:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    string tag;
    logic [79:0] vec;
    int cnt;
    int rel;
    logic [15:0] rd;
  } exp_t;
  exp_t q[$];

  // PHY model
  logic [15:0] resp = '0;
  int relCnt = 0;
  function automatic logic phyBit(int j);
    if (j == 0) return 1'b1;
    if (j == 1) return 1'b0;
    if (j <= 17) return resp[17 - j];
    return 1'b1;
  endfunction
  assign mdioIn = mdioOe ? mdioOut : phyBit(relCnt);

  // monitor
  logic [79:0] obsVec = '0;
  int obsCnt = 0, hiCnt = 0;
  logic prevMdc = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (mdc && !prevMdc) begin
        if (mdioOe) begin
          obsVec = {obsVec[78:0], mdioOut};
          obsCnt++;
        end else relCnt++;
      end
      if (mdc) hiCnt++;
      if (!mdc && prevMdc) begin
        chk(hiCnt == HALF, "R7", "mdc high length", 80'(hiCnt), 80'(HALF));
        hiCnt = 0;
      end
      prevMdc = mdc;
      if (done) begin
        if (q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 80'(1), 80'(0));
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(obsCnt == e.cnt, e.tag, "driven bit count", 80'(obsCnt), 80'(e.cnt));
          chk(obsVec == e.vec, e.tag, "driven bits", obsVec, e.vec);
          chk(relCnt == e.rel, e.tag, "released clocks R11", 80'(relCnt), 80'(e.rel));
          chk(rdData == e.rd, e.tag, "rdData R10", 80'(rdData), 80'(e.rd));
        end
        obsVec = '0;
        obsCnt = 0;
        relCnt = 0;
      end
    end
  end

  logic [15:0] lastRd = '0;

  task automatic doOp(input bit rd, input bit pre, input logic [4:0] phy,
                      input logic [5:0] ra, input logic [15:0] wd,
                      input logic [15:0] rsp, input bit poke, input string tag);
    exp_t e;
    e.tag = tag;
    e.vec = '0;
    e.cnt = 0;
    e.rel = 0;
    if (!ra[5]) begin
      if (pre) begin
        e.vec = {48'h0, 32'hFFFF_FFFF};
        e.cnt = 32;
      end
      if (rd) begin
        e.vec = {e.vec[63:0], 6'b110110, phy, ra[4:0]};
        e.cnt += 16;
        e.rel = 19;
      end else begin
        e.vec = {e.vec[47:0], 4'b0101, phy, ra[4:0], 2'b10, wd};
        e.cnt += 32;
        e.rel = 2;
      end
    end
    if (rd) lastRd = ra[5] ? 16'hFFFF : rsp;
    e.rd = lastRd;
    q.push_back(e);
    resp = rsp;
    @(negedge clk);
    start = 1'b1; isRead = rd; preambleEn = pre;
    phyAddr = phy; regAddr = ra; wrData = wd;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      // R9: a colliding request mid-frame must be dropped
      start = 1'b1; isRead = ~rd; regAddr = 6'd3; phyAddr = ~phy; wrData = ~wd;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", 80'(done), 80'(0));
    chk(busy == 1'b0, "R10", "idle after done", 80'(busy), 80'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mdc == 1'b0 && mdioOe == 1'b0 && mdioOut == 1'b1, "R1",
        "pins at reset", 80'({mdc, mdioOe, mdioOut}), 80'(3'b001));
    chk(busy == 1'b0 && done == 1'b0 && rdData == 16'h0, "R1",
        "status at reset", 80'({busy, done, rdData}), 80'(0));
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(mdioOe == 1'b0, "R11", "released while idle", 80'(mdioOe), 80'(0));
    doOp(0, 0, 5'h05, 6'h12, 16'hA5C3, 16'h0, 0, "R5 R6");
    doOp(1, 0, 5'h1F, 6'h01, 16'h0, 16'h796D, 0, "R3 R4");
    doOp(1, 1, 5'h00, 6'h1F, 16'h0, 16'h8001, 0, "R2 R3 R4");
    doOp(0, 1, 5'h0A, 6'h04, 16'h01E1, 16'h0, 1, "R2 R5 R9");
    doOp(1, 0, 5'h03, 6'd40, 16'h0, 16'h1234, 0, "R8 read");
    doOp(0, 0, 5'h03, 6'd33, 16'hBEEF, 16'h0, 0, "R8 write");
    doOp(1, 0, 5'h11, 6'h00, 16'h0, 16'h0000, 0, "R4 zero");
    repeat (50) @(negedge clk);
    chk(rdData == 16'h0000, "R10", "rdData hold", 80'(rdData), 80'(0));
    doOp(0, 0, 5'h1E, 6'h1F, 16'hFFFF, 16'h0, 0, "R5 R10");
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R9", "all frames completed", 80'(q.size()), 80'(0));
    finished = 1;
  end

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (finished || cycles > 150000) begin
      if (!finished) chk(1'b0, "WDOG", "watchdog expired", 80'(cycles), 80'(0));
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule